// File: doc/BRIEF.md
# Register-Mapped Nonvolatile Byte Array Controller

This block lets a CPU reach a small on-chip nonvolatile byte array through four byte-wide register slots. Software places a location in an address slot and, for a store, a byte in a data slot. It then starts the operation by setting a command bit in a control slot. Each command bit is honoured only if its matching enable bit was already set by an earlier control write. The command bits clear themselves when the operation finishes, so software can poll them as busy flags.

A fetch takes a fixed two bus clocks and leaves the byte in the data slot. A store is timed by a down-counter that advances only on pulses of a separate slow timing enable, so its length does not depend on the bus clock. When a store finishes, the block emits a single-cycle completion pulse for the interrupt logic. The control slot is visible only while the bank pointer selects bank 1, and the bank pointer comes out of reset at bank 0.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset the bank pointer, address slot, data slot, both enables and both command bits read 0, and the completion pulse is low.
- R2: Slot selects are 0 bank pointer (bit 0), 1 address, 2 data, 3 control. While the bank pointer is 0, slot 3 reads 0 and writes to it change nothing.
- R3: Control bits are: bit 0 fetch command, bit 1 fetch enable, bit 2 store command, bit 3 store enable. A fetch starts only if the fetch enable was already 1 before the write that sets bit 0.
- R4: A started fetch keeps bit 0 set for exactly two bus clocks, then clears it, and the data slot holds the array byte at the address slot.
- R5: The data slot keeps its value until the next fetch or store, even when the address slot changes.
- R6: A store starts only if the store enable was already 1 before the write that sets bit 2.
- R7: A store writes the data slot byte to the address slot location and clears bit 2 on exactly the WR_TICKS-th slow enable pulse after it started.
- R8: The completion output is high for exactly one bus clock, in the cycle right after the store command bit clears, and at no other time.
- R9: While either command bit is set, writes to the address, data and control slots are ignored, so a busy command bit cannot be cleared by software.
- R10: If one control write sets both command bits with both enables already 1, only the fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register slot select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for the selected slot |
| slow_tick | input | 1 | Slow timing enable for the store timer |
| wr_done | output | 1 | One-cycle store completion pulse |

## Verification
The assertions watch, on every cycle, that a fetch holds its busy bit for exactly two clocks, that no command starts without its enable set beforehand, that the completion pulse is single-cycle and matches the falling store busy flag, that the store timer stays within range, and that the address, data and control slots stay frozen while busy or outside the bank-1 window. Only the bench scenarios can show that bytes land at the right locations across the whole array and read back intact. They also show that the store lasts exactly the set number of slow pulses, that the data slot survives address changes, and that the fetch wins when both commands are set together.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_BANK = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_CTRL = 2'd3
    } slot_sel_e;

    // Control slot layout, msb first: store enable, store cmd, fetch enable, fetch cmd
    typedef struct packed {
        logic st_en;
        logic st_cmd;
        logic fe_en;
        logic fe_cmd;
    } ctrl_bits_t;

    function automatic ctrl_bits_t ctrl_from_byte(input logic [DATA_W-1:0] b);
        ctrl_bits_t c;
        c.st_en  = b[3];
        c.st_cmd = b[2];
        c.fe_en  = b[1];
        c.fe_cmd = b[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_byte(input ctrl_bits_t c);
        return {{(DATA_W-4){1'b0}}, c};
    endfunction

endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 4,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_commit) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq #(
    parameter int WR_TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start_rd,
    input  logic start_wr,
    input  logic slow_tick,
    output logic rd_busy,
    output logic wr_busy,
    output logic rd_done,
    output logic wr_commit,
    output logic wr_done
);
    localparam int TW = $clog2(WR_TICKS + 1);
    localparam logic [TW-1:0] TICK_LOAD = TW'(WR_TICKS);
    localparam logic [TW-1:0] TICK_LAST = TW'(1);

    logic          rd_phase;
    logic [TW-1:0] timer;

    assign rd_done   = rd_busy && rd_phase;
    assign wr_commit = wr_busy && slow_tick && (timer == TICK_LAST);

    // fetch: two bus clocks from start to capture
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_busy  <= 1'b0;
            rd_phase <= 1'b0;
        end else if (start_rd) begin
            rd_busy  <= 1'b1;
            rd_phase <= 1'b0;
        end else if (rd_busy) begin
            if (rd_phase) begin
                rd_busy  <= 1'b0;
                rd_phase <= 1'b0;
            end else begin
                rd_phase <= 1'b1;
            end
        end
    end

    // store: down-counter advanced by slow enable pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_busy <= 1'b0;
            timer   <= '0;
        end else if (start_wr) begin
            wr_busy <= 1'b1;
            timer   <= TICK_LOAD;
        end else if (wr_busy && slow_tick) begin
            if (timer == TICK_LAST) begin
                wr_busy <= 1'b0;
                timer   <= '0;
            end else begin
                timer <= timer - TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_done <= 1'b0;
        end else begin
            wr_done <= wr_commit;
        end
    end

    assert_fetch_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_busy) |=> rd_busy ##1 !rd_busy);

    assert_timer_range_R7: assert property (@(posedge clk) disable iff (rst)
        wr_busy |-> (timer != '0) && (timer <= TICK_LOAD));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done);

    assert_done_follows_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_busy) |-> wr_done);

    assert_not_both_R10: assert property (@(posedge clk) disable iff (rst)
        !(rd_busy && wr_busy));

endmodule

// File: rtl/nvm_regfile.sv
module nvm_regfile
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rd_busy,
    input  logic              wr_busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] fetched,
    output logic              start_rd,
    output logic              start_wr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    logic       bank_q;
    logic       fe_en_q;
    logic       st_en_q;
    logic       busy;
    logic       hit_ctrl;
    logic       hit_addr;
    logic       hit_data;
    ctrl_bits_t wr_bits;
    ctrl_bits_t rd_bits;

    assign busy     = rd_busy || wr_busy;
    assign wr_bits  = ctrl_from_byte(bus_wdata);
    assign hit_ctrl = bus_wr && (bus_sel == SEL_CTRL) && bank_q && !busy;
    assign hit_addr = bus_wr && (bus_sel == SEL_ADDR) && !busy;
    assign hit_data = bus_wr && (bus_sel == SEL_DATA) && !busy;

    // commands honour only enables stored by an earlier write; fetch wins a tie
    assign start_rd = hit_ctrl && wr_bits.fe_cmd && fe_en_q;
    assign start_wr = hit_ctrl && wr_bits.st_cmd && st_en_q && !start_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= 1'b0;
        end else if (bus_wr && bus_sel == SEL_BANK) begin
            bank_q <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fe_en_q <= 1'b0;
            st_en_q <= 1'b0;
        end else if (hit_ctrl) begin
            fe_en_q <= wr_bits.fe_en;
            st_en_q <= wr_bits.st_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (hit_addr) begin
            addr_q <= bus_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= fetched;
        end else if (hit_data) begin
            data_q <= bus_wdata;
        end
    end

    always_comb begin
        rd_bits.st_en  = st_en_q;
        rd_bits.st_cmd = wr_busy;
        rd_bits.fe_en  = fe_en_q;
        rd_bits.fe_cmd = rd_busy;
        case (bus_sel)
            SEL_BANK: bus_rdata = {{(DATA_W-1){1'b0}}, bank_q};
            SEL_ADDR: bus_rdata = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
            SEL_DATA: bus_rdata = data_q;
            default:  bus_rdata = bank_q ? ctrl_to_byte(rd_bits) : '0;
        endcase
    end

    assert_bank_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (!bank_q && bus_wr && bus_sel == SEL_CTRL) |=> $stable(fe_en_q) && $stable(st_en_q));

    assert_fetch_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_busy) |-> $past(fe_en_q));

    assert_store_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_busy) |-> $past(st_en_q));

    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));

    assert_enables_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(fe_en_q) && $stable(st_en_q));

endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int WR_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       slow_tick,
    output logic       wr_done
);
    logic              start_rd;
    logic              start_wr;
    logic              rd_busy;
    logic              wr_busy;
    logic              rd_done;
    logic              wr_commit;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] cell_byte;

    nvm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rd_busy   (rd_busy),
        .wr_busy   (wr_busy),
        .rd_done   (rd_done),
        .fetched   (cell_byte),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

    nvm_seq #(.WR_TICKS(WR_TICKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .slow_tick (slow_tick),
        .rd_busy   (rd_busy),
        .wr_busy   (wr_busy),
        .rd_done   (rd_done),
        .wr_commit (wr_commit),
        .wr_done   (wr_done)
    );

    nvm_array #(.ADDR_W(ADDR_W), .DW(DATA_W)) u_array (
        .clk       (clk),
        .wr_commit (wr_commit),
        .addr      (addr_q),
        .wdata     (data_q),
        .rdata     (cell_byte)
    );

    assert_data_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        wr_busy |=> $stable(data_q));

    assert_data_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_busy && !wr_busy && !(bus_wr && bus_sel == 2'd2)) |=> $stable(data_q));

endmodule

// File: tb/nvm_access_ctrl_tb.sv
module nvm_access_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int TICKS      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       slow_tick = 1'b0;
    logic       wr_done;

    int n_checks = 0;
    int n_fail   = 0;
    int n_done   = 0;
    int n_stores = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_access_ctrl #(.ADDR_W(AW), .WR_TICKS(TICKS)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .slow_tick (slow_tick),
        .wr_done   (wr_done)
    );

    always @(negedge clk) if (!rst && wr_done) n_done++;

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [7:0] d);
        bus_sel = sel;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic do_store(input int a, input logic [7:0] d);
        logic [7:0] v;
        wr_reg(2'd1, 8'(a));
        wr_reg(2'd2, d);
        wr_reg(2'd3, 8'h0E);
        for (int t = 1; t < TICKS; t++) pulse_tick();
        rd_reg(2'd3, v);
        check("R7 busy before last tick", v & 8'h04, 8'h04);
        check("R8 no pulse before end", {7'd0, wr_done}, 8'h00);
        pulse_tick();
        rd_reg(2'd3, v);
        check("R7 cleared on last tick", v & 8'h04, 8'h00);
        check("R8 pulse after clear", {7'd0, wr_done}, 8'h01);
        @(negedge clk);
        check("R8 pulse one cycle", {7'd0, wr_done}, 8'h00);
        n_stores++;
    endtask

    task automatic do_fetch(input int a, input logic [7:0] exp);
        logic [7:0] v;
        wr_reg(2'd1, 8'(a));
        wr_reg(2'd3, 8'h0B);
        rd_reg(2'd3, v);
        check("R4 busy first clock", v & 8'h01, 8'h01);
        @(negedge clk);
        rd_reg(2'd3, v);
        check("R4 busy second clock", v & 8'h01, 8'h01);
        @(negedge clk);
        rd_reg(2'd3, v);
        check("R4 cleared", v & 8'h01, 8'h00);
        rd_reg(2'd2, v);
        check("R4 fetched byte", v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 3; s++) begin
            rd_reg(2'(s), v);
            check("R1 reset slot", v, 8'h00);
        end
        check("R1 reset pulse", {7'd0, wr_done}, 8'h00);

        // R2 bank window
        wr_reg(2'd3, 8'h0A);
        rd_reg(2'd3, v);
        check("R2 hidden in bank0", v, 8'h00);
        wr_reg(2'd0, 8'h01);
        rd_reg(2'd0, v);
        check("R2 bank pointer", v, 8'h01);
        rd_reg(2'd3, v);
        check("R2 bank0 write ignored", v, 8'h00);
        wr_reg(2'd3, 8'h0A);
        wr_reg(2'd0, 8'h00);
        rd_reg(2'd3, v);
        check("R2 reads 0 in bank0", v, 8'h00);
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd0, 8'h01);
        rd_reg(2'd3, v);
        check("R2 enables kept", v, 8'h0A);

        // R3 fetch gated by prior enable
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd3, 8'h03);
        rd_reg(2'd3, v);
        check("R3 fetch ignored without enable", v, 8'h02);
        @(negedge clk);
        rd_reg(2'd3, v);
        check("R3 still idle", v, 8'h02);

        // R6 store gated by prior enable
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd3, 8'h0C);
        rd_reg(2'd3, v);
        check("R6 store ignored without enable", v, 8'h08);
        repeat (TICKS + 1) pulse_tick();
        check("R6 no pulse", 8'(n_done), 8'h00);

        // R7/R8 store sweep over whole array, then R4 fetch sweep
        for (int a = 0; a < (1 << AW); a++) do_store(a, pattern(a));
        for (int a = (1 << AW) - 1; a >= 0; a--) do_fetch(a, pattern(a));

        // R5 data slot kept across address change
        wr_reg(2'd1, 8'd9);
        @(negedge clk);
        rd_reg(2'd2, v);
        check("R5 data kept", v, pattern(0));

        // R9 writes ignored while busy
        wr_reg(2'd1, 8'd3);
        wr_reg(2'd2, 8'h5A);
        wr_reg(2'd3, 8'h0E);
        wr_reg(2'd1, 8'd12);
        wr_reg(2'd2, 8'hC3);
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd3, 8'h0B);
        rd_reg(2'd1, v);
        check("R9 address frozen", v, 8'd3);
        rd_reg(2'd2, v);
        check("R9 data frozen", v, 8'h5A);
        rd_reg(2'd3, v);
        check("R9 busy not cleared", v, 8'h0E);
        repeat (TICKS) pulse_tick();
        n_stores++;
        rd_reg(2'd3, v);
        check("R9 store completed", v, 8'h0A);
        do_fetch(3, 8'h5A);
        do_fetch(12, pattern(12));

        // R10 fetch wins a tie
        wr_reg(2'd1, 8'd7);
        wr_reg(2'd2, 8'hEE);
        wr_reg(2'd3, 8'h0F);
        rd_reg(2'd3, v);
        check("R10 only fetch", v, 8'h0B);
        repeat (2) @(negedge clk);
        repeat (TICKS + 1) pulse_tick();
        rd_reg(2'd2, v);
        check("R10 fetched not stored", v, pattern(7));
        check("R8 pulse count", 8'(n_done), 8'(n_stores));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule